// File: doc/BRIEF.md
# Watchdog Timer with Pretimeout Stage

This peripheral supervises software with two 32-bit down-counters. The main counter is the watchdog proper: software reloads it periodically, and if it ever runs down to zero the block records an expiry, raises its watchdog interrupt and, when the reset path is armed, requests a system reset. The second counter runs alongside it as an early-warning timer. Software loads it with a smaller count, so it reaches zero first and raises a pretimeout interrupt while there is still time to react.

Both counters advance on a common tick. The tick comes either from an internal prescaler, which divides the clock by a power of two chosen in the control register, or from an external fixed-reference tick input. Expiry events are held in sticky status flags that software clears by writing zero to them. The reset request is gated three ways: the watchdog counter must be enabled, a separate reset-out enable register must be armed, and a reset-out mask register must be cleared. After reset the mask is set, so a freshly reset block can never request a reset.

Software reaches every register through a simple word-wide write strobe and a combinational read port.

Top module: `wdt_pretimer`

## Requirements
- R1: After reset, control, status and reset-out enable read 0, the mask register reads 0x0000_0400, both counter registers read 0xFFFF_FFFF, and pre_irq, wd_irq and rst_req are low.
- R2: The control (0x00), reset-out enable (0x40) and mask (0x44) registers read back the full 32-bit value last written. Any unmapped word offset, for example 0x08, reads 0.
- R3: The watchdog counter is at 0x34 and the pretimeout counter is at 0x1C. An enabled counter decrements by one on each tick, and its register reads the remaining count. A counter whose enable is clear keeps its value. Control bit 8 enables the watchdog counter and bit 2 enables the pretimeout counter.
- R4: When an enabled counter reaches zero, it sets its sticky status flag and stays at zero. Status bit 31 is the watchdog-expired flag and status bit 8 is the pretimeout flag.
- R5: Control bits 18:16 hold a ratio r, and the prescaler ticks once every 2^r clocks. A write to the control register restarts the prescaler. With N loaded and the watchdog counter enabled by a control write, wd_irq rises on exactly the (N*2^r)-th rising edge after that write's edge.
- R6: While control bit 10 is set, ticks come from the ref_tick input: one tick per clock in which ref_tick is high, and none while it is low.
- R7: A write to status (0x04) clears each flag whose data bit is 0 and leaves alone each flag whose data bit is 1.
- R8: pre_irq is high while the pretimeout flag is set and control bit 2 is set. wd_irq equals the watchdog-expired flag.
- R9: rst_req is high only when all four of these hold: the expired flag is set, reset-out enable bit 8 is set, mask bit 10 is clear, and control bit 8 is set.
- R10: Writing a counter register loads it with the written value, even while it is counting, and a load takes priority over a decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Fixed-reference tick, one clock wide per tick |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register, word-aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pre_irq | output | 1 | Pretimeout interrupt, level |
| wd_irq | output | 1 | Watchdog expiry interrupt, level |
| rst_req | output | 1 | System reset request |

## Verification
The assertions rely on a few assumptions about the inputs:
- The ratio field changes only through a control write, and every such write also restarts the prescaler.
- A counter changes only through a register load or an enabled tick.
- A status flag falls only when software writes a zero to it.

The stimulus keeps within these assumptions. It drives every write and every ref_tick change half a cycle away from the active edge, uses word-aligned offsets only, and changes the tick source only through the control register. The expiry timing is swept over several ratios and load values. The reset gate is swept over all eight combinations of its enables while the expired flag is held.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;
    localparam int RATIO_W = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_PRE   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_WD    = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_RSTEN = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_RMASK = 8'h44;

    localparam int B_PRE_EN   = 2;
    localparam int B_WD_EN    = 8;
    localparam int B_REF_SEL  = 10;
    localparam int B_RATIO    = 16;
    localparam int B_ST_PRE   = 8;
    localparam int B_ST_WD    = 31;
    localparam int B_RST_ARM  = 8;
    localparam int B_RST_MASK = 10;

    localparam int N_CNT  = 2;
    localparam int IX_WD  = 0;
    localparam int IX_PRE = 1;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic              wd_flag;
        logic              pre_flag;
        logic [WORD_W-1:0] rst_arm;
        logic [WORD_W-1:0] rst_mask;
    } wdt_regs_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);
    localparam int CNT_W = (1 << RATIO_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] sel_mask;

    always_comb begin
        sel_mask = (CNT_W'(1) << ratio) - CNT_W'(1);
        tick     = (cnt_q & sel_mask) == sel_mask;
        cnt_d    = clr ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: with a divide ratio above one, ticks never come back to back
    a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ratio != '0 && !clr) |=> !tick);
endmodule

// File: rtl/wdt_downcnt.sv
module wdt_downcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         expire
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (load)                          val_d = load_val;
        else if (en && tick && val_q != '0) val_d = val_q - W'(1);
        expire = en && tick && !load && (val_q <= W'(1));
        value  = val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '1;
        else        val_q <= val_d;
    end

    // R4: once at zero, only a load moves the counter
    a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (val_q == '0 && !load) |=> val_q == '0);
    // R3: a disabled counter keeps its value
    a_r3_disabled_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(val_q));
    // R3: one step down per enabled tick
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !load && val_q != '0) |=> val_q == $past(val_q) - W'(1));
    // R10: a load wins over a decrement
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> val_q == $past(load_val));
endmodule

// File: rtl/wdt_pretimer.sv
module wdt_pretimer
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              pre_irq,
    output logic              wd_irq,
    output logic              rst_req
);
    localparam wdt_regs_t REGS_RST = '{
        ctrl:     '0,
        wd_flag:  1'b0,
        pre_flag: 1'b0,
        rst_arm:  '0,
        rst_mask: WORD_W'(1) << B_RST_MASK
    };

    wdt_regs_t regs_d, regs_q;

    logic              presc_tick, presc_clr, cnt_tick;
    logic [N_CNT-1:0]  cnt_en, cnt_load, cnt_exp;
    logic [WORD_W-1:0] cnt_val [N_CNT];
    logic [ADDR_W-1:0] cnt_ofs [N_CNT];

    assign cnt_ofs[IX_WD]  = OFS_WD;
    assign cnt_ofs[IX_PRE] = OFS_PRE;
    assign cnt_en[IX_WD]   = regs_q.ctrl[B_WD_EN];
    assign cnt_en[IX_PRE]  = regs_q.ctrl[B_PRE_EN];

    assign presc_clr = reg_wr && reg_addr == OFS_CTRL;
    assign cnt_tick  = regs_q.ctrl[B_REF_SEL] ? ref_tick : presc_tick;

    wdt_prescaler #(.RATIO_W(RATIO_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (presc_clr),
        .ratio (regs_q.ctrl[B_RATIO +: RATIO_W]),
        .tick  (presc_tick)
    );

    for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
        assign cnt_load[gi] = reg_wr && reg_addr == cnt_ofs[gi];
        wdt_downcnt #(.W(WORD_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (cnt_en[gi]),
            .tick     (cnt_tick),
            .load     (cnt_load[gi]),
            .load_val (reg_wdata),
            .value    (cnt_val[gi]),
            .expire   (cnt_exp[gi])
        );
    end

    always_comb begin
        regs_d = regs_q;
        if (reg_wr) begin
            case (reg_addr)
                OFS_CTRL:  regs_d.ctrl     = reg_wdata;
                OFS_RSTEN: regs_d.rst_arm  = reg_wdata;
                OFS_RMASK: regs_d.rst_mask = reg_wdata;
                OFS_STAT: begin
                    regs_d.wd_flag  = regs_q.wd_flag  & reg_wdata[B_ST_WD];
                    regs_d.pre_flag = regs_q.pre_flag & reg_wdata[B_ST_PRE];
                end
                default: ;
            endcase
        end
        if (cnt_exp[IX_WD])  regs_d.wd_flag  = 1'b1;
        if (cnt_exp[IX_PRE]) regs_d.pre_flag = 1'b1;

        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL:  reg_rdata = regs_q.ctrl;
            OFS_STAT: begin
                reg_rdata[B_ST_WD]  = regs_q.wd_flag;
                reg_rdata[B_ST_PRE] = regs_q.pre_flag;
            end
            OFS_PRE:   reg_rdata = cnt_val[IX_PRE];
            OFS_WD:    reg_rdata = cnt_val[IX_WD];
            OFS_RSTEN: reg_rdata = regs_q.rst_arm;
            OFS_RMASK: reg_rdata = regs_q.rst_mask;
            default:   reg_rdata = '0;
        endcase

        pre_irq = regs_q.pre_flag && regs_q.ctrl[B_PRE_EN];
        wd_irq  = regs_q.wd_flag;
        rst_req = regs_q.wd_flag && regs_q.rst_arm[B_RST_ARM]
                  && !regs_q.rst_mask[B_RST_MASK] && regs_q.ctrl[B_WD_EN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    // R7: the expired flag falls only on a status write with bit 31 at zero
    a_r7_sticky_wd: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.wd_flag && !(reg_wr && reg_addr == OFS_STAT && !reg_wdata[B_ST_WD]))
        |=> regs_q.wd_flag);
    // R7: the same holds for the pretimeout flag and bit 8
    a_r7_sticky_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.pre_flag && !(reg_wr && reg_addr == OFS_STAT && !reg_wdata[B_ST_PRE]))
        |=> regs_q.pre_flag);
    // R4: expiry is only recorded when the watchdog count was at one or zero
    a_r4_expiry_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(regs_q.wd_flag) |-> $past(cnt_val[IX_WD]) <= WORD_W'(1));
    // R9: no reset request while the counter is disabled
    a_r9_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> cnt_en[IX_WD]);
endmodule

// File: tb/sim_wdt_pretimer.sv
module sim_wdt_pretimer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        pre_irq, wd_irq, rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_pretimer u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pre_irq(pre_irq), .wd_irq(wd_irq), .rst_req(rst_req)
    );

    localparam logic [31:0] EN_WD  = 32'h0000_0100;
    localparam logic [31:0] EN_PRE = 32'h0000_0004;
    localparam logic [31:0] REFSEL = 32'h0000_0400;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: bench hung, got 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int cyc;
        clocks(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h04, v); chk("R1 status", v, 32'h0);
        rd(8'h40, v); chk("R1 rst enable", v, 32'h0);
        rd(8'h44, v); chk("R1 mask", v, 32'h0000_0400);
        rd(8'h34, v); chk("R1 wd count", v, 32'hFFFF_FFFF);
        rd(8'h1C, v); chk("R1 pre count", v, 32'hFFFF_FFFF);
        chk("R1 outputs", {29'h0, pre_irq, wd_irq, rst_req}, 32'h0);

        // R2 readback
        wr(8'h00, 32'hA5A0_0A0B); rd(8'h00, v); chk("R2 ctrl", v, 32'hA5A0_0A0B);
        wr(8'h40, 32'h1234_5678); rd(8'h40, v); chk("R2 rst enable", v, 32'h1234_5678);
        wr(8'h44, 32'h8765_4321); rd(8'h44, v); chk("R2 mask", v, 32'h8765_4321);
        rd(8'h08, v); chk("R2 unmapped", v, 32'h0);
        wr(8'h40, 32'h0); wr(8'h44, 32'h0000_0400); wr(8'h00, 32'h0);

        // R3 counting at ratio 0 and holding when disabled
        wr(8'h34, 32'd10);
        wr(8'h00, EN_WD);
        clocks(3);
        rd(8'h34, v); chk("R3 count down", v, 32'd7);
        wr(8'h00, 32'h0);
        rd(8'h34, v); v = v;
        begin
            logic [31:0] held;
            held = v;
            clocks(5);
            rd(8'h34, v); chk("R3 disabled holds", v, held);
        end

        // R10 load while running
        wr(8'h00, EN_WD);
        wr(8'h34, 32'd100);
        rd(8'h34, v); chk("R10 load value", v, 32'd100);
        clocks(1);
        rd(8'h34, v); chk("R10 counts from load", v, 32'd99);
        wr(8'h00, 32'h0);

        // R5 sweep of ratio and load value
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < 4; k++) begin
                int n;
                n = (k == 3) ? 5 : k + 1;
                wr(8'h00, 32'h0);
                wr(8'h04, 32'h0);
                wr(8'h34, n);
                wr(8'h00, (r << 16) | EN_WD);
                cyc = 0;
                while (!wd_irq && cyc < 2000) begin
                    @(posedge clk); cyc++; @(negedge clk);
                end
                chk($sformatf("R5 expiry ratio %0d load %0d", r, n), cyc, n << r);
            end
        end

        // R4 hold at zero and sticky flag
        clocks(4);
        rd(8'h34, v); chk("R4 counter holds zero", v, 32'h0);
        rd(8'h04, v); chk("R4 expired flag", v, 32'h8000_0000);

        // R9 reset gate sweep with the flag set
        for (int c = 0; c < 8; c++) begin
            wr(8'h40, c[0] ? 32'h100 : 32'h0);
            wr(8'h44, c[1] ? 32'h400 : 32'h0);
            wr(8'h00, c[2] ? EN_WD : 32'h0);
            chk($sformatf("R9 gate combo %0d", c), rst_req,
                (c[0] && !c[1] && c[2]) ? 32'h1 : 32'h0);
        end
        wr(8'h34, 32'd1000);
        wr(8'h04, 32'h0);
        chk("R9 no request without flag", rst_req, 32'h0);
        chk("R8 wd_irq follows flag", wd_irq, 32'h0);

        // R8 and R7 pretimeout
        wr(8'h00, 32'h0);
        wr(8'h34, 32'd20);
        wr(8'h1C, 32'd5);
        wr(8'h00, EN_WD | EN_PRE);
        clocks(5);
        chk("R8 pre_irq raised", pre_irq, 32'h1);
        chk("R8 wd_irq not yet", wd_irq, 32'h0);
        rd(8'h04, v); chk("R4 pre flag", v, 32'h0000_0100);
        clocks(16);
        rd(8'h04, v); chk("R7 both flags", v, 32'h8000_0100);
        wr(8'h00, 32'h0);
        chk("R8 pre_irq gated by enable", pre_irq, 32'h0);
        wr(8'h04, 32'h0000_0100);
        rd(8'h04, v); chk("R7 clear wd keep pre", v, 32'h0000_0100);
        wr(8'h04, 32'h8000_0000);
        rd(8'h04, v); chk("R7 clear pre", v, 32'h0);

        // R6 fixed reference tick
        wr(8'h34, 32'd50);
        wr(8'h00, REFSEL | EN_WD);
        clocks(5);
        rd(8'h34, v); chk("R6 no ref tick", v, 32'd50);
        ref_tick = 1'b1;
        clocks(3);
        ref_tick = 1'b0;
        rd(8'h34, v); chk("R6 three ref ticks", v, 32'd47);
        wr(8'h00, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule